// File: doc/BRIEF.md
# Synchronous Byte-FIFO Bus Device Model

This block stands in for the device end of a clocked 8-bit parallel FIFO bus. A host controller under test talks to it exactly as it would to a real bridge part: the model shows a "data available" flag and a "space available" flag, both active low, and answers the host's output-enable, read-strobe and write-strobe inputs. Bytes meant for the host come from a local valid/ready input stream and wait in a receive queue. Bytes the host writes land in a transmit queue that a local valid/ready output stream drains. The host side and the local side run from the same clock, which in a chip is the bus clock.

The model is useful for closing a loop around a host controller. Tie the local output back to the local input and every byte the host writes comes back to it in order. The flags follow the queue occupancy on every edge, so the host sees back-pressure as soon as a queue fills and sees "no data" as soon as the last byte has been taken.

Top module: `sfe_dev_emu`

## Requirements
- R1: After a synchronous reset, `rxf_n` is 1, `txe_n` is 0, `ltx_valid` is 0, `lrx_ready` is 1 and, with `oe_n` high, `bus_oe` is 0.
- R2: `rxf_n` is 0 exactly while the receive queue holds at least one byte. It goes low right after the edge that accepts a local byte into an empty queue.
- R3: `bus_oe` is 1 exactly while `oe_n` is 0. `bus_dout` carries the oldest unread byte of the receive queue whenever `rxf_n` is 0.
- R4: On an edge where `rd_n` and `rxf_n` are both 0, the oldest byte is removed and `bus_dout` shows the next byte after that edge. While `rd_n` is 1, `bus_dout` holds its value (wait states).
- R5: When the edge that removes the last stored byte passes and no local byte arrives on that edge, `rxf_n` is 1 right after it.
- R6: `rd_n` low while `rxf_n` is 1 removes nothing. Bytes pushed afterwards are read back in order, with none lost or repeated.
- R7: `txe_n` is 0 while the transmit queue has a free entry. It is 1 once the queue holds DEPTH bytes, and it drops again after one byte is drained.
- R8: A byte from `bus_din` is stored only on an edge where `wr_n` and `txe_n` are both 0. A write strobe while `txe_n` is 1 stores nothing.
- R9: `ltx_valid` is 1 while the transmit queue is not empty, and `ltx_data` shows the oldest stored byte. That byte is removed on an edge with `ltx_valid` and `ltx_ready` both 1, and it holds while `ltx_ready` is 0.
- R10: `lrx_ready` is 0 while the receive queue holds DEPTH bytes. A local byte offered then is dropped and never reaches the host.
- R11: A read and a local push on the same edge leave the occupancy unchanged, and the byte order is kept. The same holds for a host write and a local drain on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lrx_valid | input | 1 | Local byte offered for the host |
| lrx_ready | output | 1 | Receive queue can take a local byte |
| lrx_data | input | DW | Local byte offered for the host |
| ltx_valid | output | 1 | A host-written byte is waiting |
| ltx_ready | input | 1 | Local consumer takes the waiting byte |
| ltx_data | output | DW | Oldest host-written byte |
| rxf_n | output | 1 | Low while data is available to the host |
| txe_n | output | 1 | Low while the device can accept a host byte |
| oe_n | input | 1 | Host output enable, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| bus_din | input | DW | Data bus as driven by the host |
| bus_dout | output | DW | Data bus as driven by the device |
| bus_oe | output | 1 | Device drives the data bus |

## Verification
The bench builds the block with DW = 8 and DEPTH = 4, a non-default depth that is still a power of two. With four entries, both the full receive queue and the full transmit queue are reached after a handful of bytes. The bench can then press strobes against a full transmit queue and offer local bytes to a full receive queue within a short run. The short depth also makes the pointers wrap several times over the run, so the ordering checks cover wrap-around reads and writes as well as straight runs.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  // Pointer width for a queue of d entries (at least one bit).
  function automatic int unsigned ptr_w(input int unsigned d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction

  // Occupancy counter width able to hold the value d.
  function automatic int unsigned cnt_w(input int unsigned d);
    return $clog2(d + 1);
  endfunction
endpackage

// File: rtl/sfe_queue.sv
module sfe_queue #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                push,
  input  logic [W-1:0]                        wdata,
  input  logic                                pop,
  output logic [W-1:0]                        rdata,
  output logic [sfe_pkg::cnt_w(DEPTH)-1:0]    count
);
  localparam int unsigned AW = sfe_pkg::ptr_w(DEPTH);
  localparam int unsigned CW = sfe_pkg::cnt_w(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
  logic          is_full, is_empty, do_push, do_pop;

  assign is_full  = (count == CW'(DEPTH));
  assign is_empty = (count == '0);
  assign do_push  = push && !is_full;
  assign do_pop   = pop && !is_empty;

  // Pointer advance: free wrap for power-of-two depth, compare otherwise.
  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
    end else begin : g_wrap
      assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  endgenerate

  // Storage array: no reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr_nx;
      if (do_pop)  rptr <= rptr_nx;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfe_host_rd.sv
module sfe_host_rd #(
  parameter int unsigned DW = 8
) (
  input  logic          oe_n,
  input  logic          rd_n,
  input  logic          q_empty,
  input  logic [DW-1:0] q_head,
  output logic          q_pop,
  output logic          rxf_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe
);
  // Data-available flag tracks occupancy directly; a strobe against an
  // empty queue is discarded.
  assign rxf_n    = q_empty;
  assign q_pop    = !rd_n && !q_empty;
  assign bus_oe   = !oe_n;
  assign bus_dout = q_head;
endmodule

// File: rtl/sfe_host_wr.sv
module sfe_host_wr #(
  parameter int unsigned DW = 8
) (
  input  logic          wr_n,
  input  logic          q_full,
  input  logic [DW-1:0] bus_din,
  output logic          q_push,
  output logic [DW-1:0] q_wdata,
  output logic          txe_n
);
  // A byte is taken only when both the strobe and the space flag are low.
  assign txe_n   = q_full;
  assign q_push  = !wr_n && !q_full;
  assign q_wdata = bus_din;
endmodule

// File: rtl/sfe_dev_emu.sv
module sfe_dev_emu #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lrx_valid,
  output logic          lrx_ready,
  input  logic [DW-1:0] lrx_data,
  output logic          ltx_valid,
  input  logic          ltx_ready,
  output logic [DW-1:0] ltx_data,
  output logic          rxf_n,
  output logic          txe_n,
  input  logic          oe_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe
);
  localparam int unsigned CW = sfe_pkg::cnt_w(DEPTH);

  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [DW-1:0] rx_head, tx_wdata;
  logic          rx_push, rx_pop, tx_push, tx_pop;
  logic          rx_full, rx_empty, tx_full, tx_empty;

  assign rx_full  = (rx_cnt == CW'(DEPTH));
  assign rx_empty = (rx_cnt == '0);
  assign tx_full  = (tx_cnt == CW'(DEPTH));
  assign tx_empty = (tx_cnt == '0);

  // Local side
  assign lrx_ready = !rx_full;
  assign rx_push   = lrx_valid && !rx_full;
  assign ltx_valid = !tx_empty;
  assign tx_pop    = ltx_ready && !tx_empty;

  sfe_queue #(.W(DW), .DEPTH(DEPTH)) rx_q (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(lrx_data),
    .pop(rx_pop), .rdata(rx_head), .count(rx_cnt)
  );

  sfe_queue #(.W(DW), .DEPTH(DEPTH)) tx_q (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_wdata),
    .pop(tx_pop), .rdata(ltx_data), .count(tx_cnt)
  );

  sfe_host_rd #(.DW(DW)) rd_i (
    .oe_n(oe_n), .rd_n(rd_n), .q_empty(rx_empty), .q_head(rx_head),
    .q_pop(rx_pop), .rxf_n(rxf_n), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  sfe_host_wr #(.DW(DW)) wr_i (
    .wr_n(wr_n), .q_full(tx_full), .bus_din(bus_din),
    .q_push(tx_push), .q_wdata(tx_wdata), .txe_n(txe_n)
  );
endmodule

// File: rtl/sfe_dev_emu_chk.sv
module sfe_dev_emu_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             lrx_valid,
  input logic                             lrx_ready,
  input logic                             ltx_valid,
  input logic                             ltx_ready,
  input logic                             rxf_n,
  input logic                             txe_n,
  input logic                             oe_n,
  input logic                             rd_n,
  input logic                             wr_n,
  input logic                             bus_oe,
  input logic [sfe_pkg::cnt_w(DEPTH)-1:0] rx_cnt,
  input logic [sfe_pkg::cnt_w(DEPTH)-1:0] tx_cnt
);
  localparam int unsigned CW = sfe_pkg::cnt_w(DEPTH);

  // R2
  rx_avail_chk: assert property (@(posedge clk) disable iff (rst)
    (lrx_valid && lrx_ready) |=> !rxf_n);

  // R3
  oe_drive_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !oe_n);

  // R4
  rd_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !rxf_n && !(lrx_valid && lrx_ready)) |=> (rx_cnt == CW'($past(rx_cnt) - 1'b1)));

  // R5
  last_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !rxf_n && rx_cnt == CW'(1) && !(lrx_valid && lrx_ready)) |=> rxf_n);

  // R6
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rxf_n && !rd_n && !lrx_valid) |=> rxf_n);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt == CW'(DEPTH)) |-> txe_n);

  // R8
  wr_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !txe_n && !(ltx_valid && ltx_ready)) |=> (tx_cnt == CW'($past(tx_cnt) + 1'b1)));

  // R8
  wr_block_chk: assert property (@(posedge clk) disable iff (rst)
    (txe_n && !(ltx_valid && ltx_ready)) |=> $stable(tx_cnt));

  // R10
  rx_full_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == CW'(DEPTH)) |-> !lrx_ready);
endmodule

bind sfe_dev_emu sfe_dev_emu_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .lrx_valid(lrx_valid), .lrx_ready(lrx_ready),
  .ltx_valid(ltx_valid), .ltx_ready(ltx_ready), .rxf_n(rxf_n), .txe_n(txe_n),
  .oe_n(oe_n), .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt)
);

// File: tb/sfe_dev_emu_tb_top.sv
`timescale 1ns/1ps
module sfe_dev_emu_tb_top;
  localparam int unsigned DW    = 8;
  localparam int unsigned DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          lrx_valid, lrx_ready, ltx_valid, ltx_ready;
  logic [DW-1:0] lrx_data, ltx_data, bus_din, bus_dout;
  logic          rxf_n, txe_n, oe_n, rd_n, wr_n, bus_oe;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sfe_dev_emu #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .lrx_valid(lrx_valid), .lrx_ready(lrx_ready),
    .lrx_data(lrx_data), .ltx_valid(ltx_valid), .ltx_ready(ltx_ready),
    .ltx_data(ltx_data), .rxf_n(rxf_n), .txe_n(txe_n), .oe_n(oe_n),
    .rd_n(rd_n), .wr_n(wr_n), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_oe(bus_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: inputs set before the edge, outputs sampled at the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; lrx_valid = 1'b0; lrx_data = '0; ltx_ready = 1'b0;
    oe_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; bus_din = '0;
    repeat (3) step();
    rst = 1'b0;
    #1;
    check("R1 rxf_n", rxf_n, 1);
    check("R1 txe_n", txe_n, 0);
    check("R1 ltx_valid", ltx_valid, 0);
    check("R1 lrx_ready", lrx_ready, 1);
    check("R1 bus_oe", bus_oe, 0);
  endtask

  task automatic t_read_burst();
    lrx_valid = 1'b1; lrx_data = 8'hA0;
    step();
    check("R2 rxf_n after first byte", rxf_n, 0);
    lrx_data = 8'hA1; step();
    lrx_data = 8'hA2; step();
    lrx_valid = 1'b0;
    oe_n = 1'b0; #1;
    check("R3 bus_oe with oe_n low", bus_oe, 1);
    check("R3 head byte", bus_dout, 8'hA0);
    rd_n = 1'b0; step();
    check("R4 advance", bus_dout, 8'hA1);
    rd_n = 1'b1; step();
    check("R4 wait state hold", bus_dout, 8'hA1);
    rd_n = 1'b0; step();
    check("R4 second advance", bus_dout, 8'hA2);
    check("R2 still available", rxf_n, 0);
    step();
    check("R5 rxf_n after last byte", rxf_n, 1);
    step(); step();
    check("R6 empty read keeps rxf_n", rxf_n, 1);
    rd_n = 1'b1;
    lrx_valid = 1'b1; lrx_data = 8'hB0; step();
    lrx_data = 8'hB1; step();
    lrx_valid = 1'b0;
    check("R6 first byte after empty reads", bus_dout, 8'hB0);
    rd_n = 1'b0; step();
    check("R6 second byte after empty reads", bus_dout, 8'hB1);
    step();
    check("R6 drained", rxf_n, 1);
    rd_n = 1'b1; oe_n = 1'b1; #1;
    check("R3 bus released", bus_oe, 0);
  endtask

  task automatic t_rx_full();
    lrx_valid = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      lrx_data = 8'h10 + 8'(i);
      step();
      check("R10 lrx_ready while filling", lrx_ready, (i + 1 < DEPTH) ? 1 : 0);
    end
    lrx_data = 8'hEE;
    step(); step();
    check("R10 ready stays low when full", lrx_ready, 0);
    lrx_valid = 1'b0;
    oe_n = 1'b0; rd_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      check("R10 stored order", bus_dout, 8'h10 + 8'(i));
      step();
    end
    check("R10 offered byte dropped", rxf_n, 1);
    rd_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_tx_fill_drain();
    ltx_ready = 1'b0; wr_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      bus_din = 8'h30 + 8'(i);
      check("R7 space while not full", txe_n, 0);
      step();
    end
    check("R7 txe_n when full", txe_n, 1);
    check("R9 head held without ready", ltx_data, 8'h30);
    bus_din = 8'hEE;
    step(); step();
    wr_n = 1'b1;
    check("R9 valid when not empty", ltx_valid, 1);
    ltx_ready = 1'b1;
    step();
    check("R7 space after one drain", txe_n, 0);
    for (int i = 1; i < DEPTH; i++) begin
      check("R9 drain order", ltx_data, 8'h30 + 8'(i));
      step();
    end
    check("R8 blocked writes not stored", ltx_valid, 0);
    ltx_ready = 1'b0;
  endtask

  task automatic t_concurrent();
    lrx_valid = 1'b1; lrx_data = 8'h50; step();
    lrx_data = 8'h51; rd_n = 1'b0; oe_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R11 rx order under push+pop", bus_dout, 8'h50 + 8'(i));
      step();
      lrx_data = 8'h52 + 8'(i);
    end
    lrx_valid = 1'b0;
    check("R11 rx occupancy kept", rxf_n, 0);
    check("R11 rx last byte", bus_dout, 8'h54);
    step();
    check("R11 rx empty at end", rxf_n, 1);
    rd_n = 1'b1; oe_n = 1'b1;
    wr_n = 1'b0; ltx_ready = 1'b1; bus_din = 8'h60; step();
    for (int i = 0; i < 3; i++) begin
      check("R11 tx order under write+drain", ltx_data, 8'h60 + 8'(i));
      check("R11 tx space kept", txe_n, 0);
      bus_din = 8'h61 + 8'(i);
      step();
    end
    wr_n = 1'b1; step();
    check("R11 tx empty at end", ltx_valid, 0);
    ltx_ready = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_read_burst();
    t_rx_full();
    t_tx_fill_drain();
    t_concurrent();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule